// File: doc/BRIEF.md
# CPU Memory Map Decoder with Page Translation

This block sits between an 8-bit CPU and the memory system of a banked home computer. It sees every CPU address and decides what that address is: internal ROM, cartridge ROM, RAM, or the I/O page. All region outputs are combinational from the current address and the stored configuration. A RAM access gets a 21-bit physical address, which reaches a 2 MB space through eight 8 KB page entries. A ROM access skips translation, and the untouched CPU address is handed to the expansion port.

Software programs the block through a small register-write port. Eight page entries and one control register set the map layout, the translation mode and the fitted RAM. The fitted-RAM setting places a floor in the physical space. A translated RAM access that lands below this floor is flagged and its write strobe is blocked. CPU accesses are not a stream: the CPU holds an address for as long as it needs, and the outputs follow it with no handshake. Configuration writes are single-cycle strobes with no back-pressure, so every write is taken.

Top module: `memmap_decoder`

## Requirements
- R1: After reset, the map is 32 KB of RAM at 0x0000-0x7FFF and internal ROM at 0x8000-0xFDFF. Translation is off and one small bank is fitted. Every page entry i holds 0xF8+i.
- R2: The control register sits at configuration address 8. Its bits [1:0] select the map. 00 places internal ROM at 0x8000-0xBFFF and cartridge ROM at 0xC000-0xFDFF. 01 places internal ROM at 0x8000-0xFDFF. 10 places cartridge ROM at 0x8000-0xFDFF. 11 makes all of 0x0000-0xFDFF RAM. Under every map, 0x0000-0x7FFF is RAM.
- R3: Addresses 0xFE00-0xFEFF are always RAM, whatever the map setting.
- R4: Addresses 0xFF00-0xFFFF assert only sel_io. No ROM or RAM select and no ram_we are asserted there.
- R5: Exactly one of sel_rom_int, sel_rom_ext, sel_ram and sel_io is high for any address.
- R6: On a ROM access, exp_addr equals cpu_addr and ram_addr is zero. Otherwise exp_addr is zero.
- R7: When control bit 2 is 1, a RAM access has ram_addr = {entry[cpu_addr[15:13]], cpu_addr[12:0]}.
- R8: When control bit 2 is 0, a RAM access has ram_addr = {5'b11111, cpu_addr[15:0]}, which is a fixed identity map into the top 64 KB.
- R9: A write to configuration address i (0-7) replaces page entry i with cfg_wdata.
- R10: Control bit 3 selects two banks (1) or one bank (0). Control bit 4 selects 512 KB banks (1) or 128 KB banks (0). The floor is 2 MB minus the fitted size. A RAM access whose physical page lies below the floor raises ram_fault.
- R11: ram_we is high only for a RAM access with cpu_rw = 0 and no fault.
- R12: A configuration write takes effect at the clock edge that samples it. During the write cycle itself, decoding still uses the old setting. Writes to configuration addresses 9-15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| sel_rom_int | output | 1 | Internal ROM selected |
| sel_rom_ext | output | 1 | Cartridge ROM selected |
| sel_ram | output | 1 | RAM selected |
| sel_io | output | 1 | I/O page selected |
| exp_addr | output | 16 | Untranslated address to expansion port on ROM access |
| ram_addr | output | 21 | Physical RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_fault | output | 1 | RAM access below the fitted floor |

## Verification
A configuration write and a decode of the address it affects can occur in the same cycle. To provoke this, the bench holds an address in the ROM window and pulses a map change to all-RAM. It checks that the outputs still report ROM before the edge and report RAM after it. Fault detection and translation also fall in the same cycle. Entries are programmed just below and just above the floor for every bank setting, so that ram_fault, ram_we and ram_addr are judged together on every page.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  typedef enum logic [1:0] {
    MAP_SPLIT = 2'b00,
    MAP_INT32 = 2'b01,
    MAP_EXT32 = 2'b10,
    MAP_ALLRAM = 2'b11
  } map_mode_e;

  typedef struct packed {
    logic      dense;
    logic      two_banks;
    logic      xlate_en;
    map_mode_e mode;
  } map_ctrl_t;

  typedef enum logic [1:0] {
    RGN_RAM  = 2'd0,
    RGN_INT  = 2'd1,
    RGN_EXT  = 2'd2,
    RGN_IO   = 2'd3
  } region_e;

  localparam logic [7:0] IO_PAGE_HI   = 8'hFF;
  localparam logic [7:0] KEEP_PAGE_HI = 8'hFE;

endpackage

// File: rtl/mm_cfg_regs.sv
module mm_cfg_regs
  import memmap_pkg::*;
#(
  parameter int PAGE_SEL_W = 3,
  parameter int ENTRY_W    = 8,
  parameter int CFG_AW     = 4
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         cfg_we,
  input  logic [CFG_AW-1:0]                            cfg_addr,
  input  logic [ENTRY_W-1:0]                           cfg_wdata,
  output map_ctrl_t                                    ctrl,
  output logic [(1<<PAGE_SEL_W)-1:0][ENTRY_W-1:0]      page_tbl
);
  localparam int N_ENT = 1 << PAGE_SEL_W;
  localparam int CTRL_W = $bits(map_ctrl_t);

  // page entries: reset to the top N_ENT pages of physical space
  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    localparam logic [ENTRY_W-1:0] RST_PAGE = ENTRY_W'((1 << ENTRY_W) - N_ENT + i);
    logic [ENTRY_W-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent_q <= RST_PAGE;
      else if (cfg_we && cfg_addr == CFG_AW'(i))
        ent_q <= cfg_wdata;
    end
    assign page_tbl[i] = ent_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl.mode      <= MAP_INT32;
      ctrl.xlate_en  <= 1'b0;
      ctrl.two_banks <= 1'b0;
      ctrl.dense     <= 1'b0;
    end else if (cfg_we && cfg_addr == CFG_AW'(N_ENT)) begin
      ctrl <= map_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
    end
  end

endmodule

// File: rtl/mm_region_decode.sv
module mm_region_decode
  import memmap_pkg::*;
(
  input  logic [7:0] addr_hi,
  input  map_mode_e  mode,
  output region_e    region
);
  always_comb begin
    if (addr_hi == IO_PAGE_HI)
      region = RGN_IO;
    else if (addr_hi == KEEP_PAGE_HI || !addr_hi[7])
      region = RGN_RAM;
    else begin
      unique case (mode)
        MAP_SPLIT:  region = addr_hi[6] ? RGN_EXT : RGN_INT;
        MAP_INT32:  region = RGN_INT;
        MAP_EXT32:  region = RGN_EXT;
        default:    region = RGN_RAM;
      endcase
    end
  end
endmodule

// File: rtl/mm_page_xlate.sv
module mm_page_xlate #(
  parameter int CPU_AW          = 16,
  parameter int PAGE_OFS_W      = 13,
  parameter int ENTRY_W         = 8,
  parameter int SMALL_BANK_BYTES = 131072,
  parameter int LARGE_BANK_BYTES = 524288,
  localparam int PAGE_SEL_W     = CPU_AW - PAGE_OFS_W,
  localparam int PHYS_W         = ENTRY_W + PAGE_OFS_W
) (
  input  logic [CPU_AW-1:0]                       cpu_addr,
  input  logic                                    xlate_en,
  input  logic                                    two_banks,
  input  logic                                    dense,
  input  logic [(1<<PAGE_SEL_W)-1:0][ENTRY_W-1:0] page_tbl,
  output logic [PHYS_W-1:0]                       phys_addr,
  output logic                                    below_floor
);
  localparam int SMALL_PAGES = SMALL_BANK_BYTES >> PAGE_OFS_W;
  localparam int LARGE_PAGES = LARGE_BANK_BYTES >> PAGE_OFS_W;
  localparam int TOTAL_PAGES = 1 << ENTRY_W;

  logic [PAGE_SEL_W-1:0] sel;
  logic [ENTRY_W-1:0]    page;
  logic [ENTRY_W:0]      fitted_pages;
  logic [ENTRY_W:0]      floor_page;

  assign sel = cpu_addr[CPU_AW-1 -: PAGE_SEL_W];

  always_comb begin
    if (xlate_en)
      page = page_tbl[sel];
    else
      page = {{(ENTRY_W-PAGE_SEL_W){1'b1}}, sel};
  end

  always_comb begin
    fitted_pages = dense ? (ENTRY_W+1)'(LARGE_PAGES) : (ENTRY_W+1)'(SMALL_PAGES);
    if (two_banks)
      fitted_pages = fitted_pages << 1;
    floor_page = (ENTRY_W+1)'(TOTAL_PAGES) - fitted_pages;
  end

  assign below_floor = {1'b0, page} < floor_page;
  assign phys_addr   = {page, cpu_addr[PAGE_OFS_W-1:0]};

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter int CPU_AW     = 16,
  parameter int PAGE_OFS_W = 13,
  parameter int ENTRY_W    = 8,
  parameter int CFG_AW     = 4,
  localparam int PAGE_SEL_W = CPU_AW - PAGE_OFS_W,
  localparam int PHYS_W     = ENTRY_W + PAGE_OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ENTRY_W-1:0] cfg_wdata,
  output logic              sel_rom_int,
  output logic              sel_rom_ext,
  output logic              sel_ram,
  output logic              sel_io,
  output logic [CPU_AW-1:0] exp_addr,
  output logic [PHYS_W-1:0] ram_addr,
  output logic              ram_we,
  output logic              ram_fault
);
  map_ctrl_t                                ctrl;
  logic [(1<<PAGE_SEL_W)-1:0][ENTRY_W-1:0]  page_tbl;
  region_e                                  region;
  logic [PHYS_W-1:0]                        xl_addr;
  logic                                     below_floor;
  logic                                     is_rom;

  mm_cfg_regs #(
    .PAGE_SEL_W (PAGE_SEL_W),
    .ENTRY_W    (ENTRY_W),
    .CFG_AW     (CFG_AW)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .ctrl      (ctrl),
    .page_tbl  (page_tbl)
  );

  mm_region_decode u_rgn (
    .addr_hi (cpu_addr[CPU_AW-1 -: 8]),
    .mode    (ctrl.mode),
    .region  (region)
  );

  mm_page_xlate #(
    .CPU_AW     (CPU_AW),
    .PAGE_OFS_W (PAGE_OFS_W),
    .ENTRY_W    (ENTRY_W)
  ) u_xlate (
    .cpu_addr    (cpu_addr),
    .xlate_en    (ctrl.xlate_en),
    .two_banks   (ctrl.two_banks),
    .dense       (ctrl.dense),
    .page_tbl    (page_tbl),
    .phys_addr   (xl_addr),
    .below_floor (below_floor)
  );

  assign sel_rom_int = (region == RGN_INT);
  assign sel_rom_ext = (region == RGN_EXT);
  assign sel_ram     = (region == RGN_RAM);
  assign sel_io      = (region == RGN_IO);
  assign is_rom      = sel_rom_int | sel_rom_ext;

  // ROM bypasses translation entirely
  assign exp_addr  = is_rom ? cpu_addr : '0;
  assign ram_addr  = sel_ram ? xl_addr : '0;
  assign ram_fault = sel_ram & below_floor;
  assign ram_we    = sel_ram & ~cpu_rw & ~below_floor;

endmodule

// File: rtl/memmap_decoder_checker.sv
module memmap_decoder_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_rw,
  input logic        cfg_we,
  input logic [3:0]  cfg_addr,
  input logic [7:0]  cfg_wdata,
  input logic        sel_rom_int,
  input logic        sel_rom_ext,
  input logic        sel_ram,
  input logic        sel_io,
  input logic [15:0] exp_addr,
  input logic [20:0] ram_addr,
  input logic        ram_we,
  input logic        ram_fault
);
  a_r3_keep_page_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:8] == 8'hFE) |-> sel_ram);

  a_r4_io_page_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:8] == 8'hFF) |-> (sel_io && !sel_ram && !ram_we));

  a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sel_rom_int, sel_rom_ext, sel_ram, sel_io}) == 1);

  a_r6_rom_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rom_int || sel_rom_ext) |-> (exp_addr == cpu_addr && ram_addr == 21'd0 && !ram_we));

  a_r10_fault_in_ram: assert property (@(posedge clk) disable iff (!rst_n)
    ram_fault |-> sel_ram);

  a_r11_we_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (sel_ram && !cpu_rw && !ram_fault));

  a_r12_allram_next: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 4'd8 && cfg_wdata[1:0] == 2'b11) |=> (sel_ram || sel_io));

  a_r11_read_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rw |-> !ram_we);

endmodule

bind memmap_decoder memmap_decoder_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_addr    (cpu_addr),
  .cpu_rw      (cpu_rw),
  .cfg_we      (cfg_we),
  .cfg_addr    (cfg_addr),
  .cfg_wdata   (cfg_wdata),
  .sel_rom_int (sel_rom_int),
  .sel_rom_ext (sel_rom_ext),
  .sel_ram     (sel_ram),
  .sel_io      (sel_io),
  .exp_addr    (exp_addr),
  .ram_addr    (ram_addr),
  .ram_we      (ram_we),
  .ram_fault   (ram_fault)
);

// File: tb/memmap_decoder_bench.sv
`timescale 1ns/1ps
module memmap_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0;
  logic        cpu_rw = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = 4'h0;
  logic [7:0]  cfg_wdata = 8'h0;
  logic        sel_rom_int, sel_rom_ext, sel_ram, sel_io;
  logic [15:0] exp_addr;
  logic [20:0] ram_addr;
  logic        ram_we, ram_fault;

  always #5 clk = ~clk;

  memmap_decoder u_memmap_decoder (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .sel_rom_int(sel_rom_int), .sel_rom_ext(sel_rom_ext), .sel_ram(sel_ram),
    .sel_io(sel_io), .exp_addr(exp_addr), .ram_addr(ram_addr),
    .ram_we(ram_we), .ram_fault(ram_fault)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench copy of the programmed state, written only by the bench
  logic [1:0] m_mode = 2'b01;
  logic       m_xen = 1'b0, m_two = 1'b0, m_dense = 1'b0;
  logic [7:0] m_tbl [8];

  function automatic logic [42:0] model(logic [15:0] a, logic rw);
    logic ri, re, rm, io, flt, we;
    logic [7:0] page;
    int fitted, floorp;
    logic [15:0] ea;
    logic [20:0] ra;
    ri = 0; re = 0; rm = 0; io = 0;
    if (a[15:8] == 8'hFF) io = 1;
    else if (a[15:8] == 8'hFE || !a[15]) rm = 1;
    else case (m_mode)
      2'b00: if (a[14]) re = 1; else ri = 1;
      2'b01: ri = 1;
      2'b10: re = 1;
      default: rm = 1;
    endcase
    page = m_xen ? m_tbl[a[15:13]] : {5'b11111, a[15:13]};
    fitted = (m_dense ? 64 : 16) * (m_two ? 2 : 1);
    floorp = 256 - fitted;
    flt = rm && (int'(page) < floorp);
    we = rm && !rw && !flt;
    ea = (ri || re) ? a : 16'h0;
    ra = rm ? {page, a[12:0]} : 21'h0;
    return {ri, re, rm, io, ea, ra, we, flt};
  endfunction

  task automatic apply(input logic [15:0] a, input logic rw, input string tag);
    logic [42:0] exp_v, act_v;
    @(negedge clk);
    cpu_addr = a; cpu_rw = rw;
    #1;
    exp_v = model(a, rw);
    act_v = {sel_rom_int, sel_rom_ext, sel_ram, sel_io, exp_addr, ram_addr, ram_we, ram_fault};
    n_vec++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s addr=%h rw=%b actual=%h expected=%h", tag, a, rw, act_v, exp_v);
    end
  endtask

  task automatic cfg_write(input logic [3:0] ad, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (ad < 4'd8) m_tbl[ad[2:0]] = d;
    else if (ad == 4'd8) begin
      m_mode = d[1:0]; m_xen = d[2]; m_two = d[3]; m_dense = d[4];
    end
  endtask

  task automatic sweep(input string tag);
    for (int h = 0; h < 256; h++) begin
      logic [7:0] hb;
      hb = 8'(h);
      apply({hb, hb ^ 8'hA5}, hb[0], tag);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_tbl[i] = 8'hF8 + 8'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset map, identity translation, default entries
    sweep("R1 reset map");
    // R2/R3/R4/R5/R6/R7/R8/R11 all maps x translation, varied entries
    for (int md = 0; md < 4; md++) begin
      for (int xe = 0; xe < 2; xe++) begin
        for (int i = 0; i < 8; i++)
          cfg_write(4'(i), 8'((i * 53 + md * 17 + xe * 90 + 200) & 255)); // R9
        cfg_write(4'd8, {5'b0, 1'(xe), 2'(md)});
        sweep("R2 R3 R4 R5 R6 R7 R8 R9 R11 map sweep");
      end
    end
    // R10 floor for each bank setting, entries straddling the floor
    for (int b = 0; b < 4; b++) begin
      int fl;
      fl = 256 - ((b[1] ? 64 : 16) * (b[0] ? 2 : 1));
      for (int i = 0; i < 8; i++) cfg_write(4'(i), 8'(fl - 4 + i));
      cfg_write(4'd8, {3'b0, 1'(b[1]), 1'(b[0]), 1'b1, 2'b11});
      sweep("R10 floor fault");
    end
    // R12 same-cycle config write: old setting holds until the edge
    cfg_write(4'd8, 8'h01);
    @(negedge clk);
    cpu_addr = 16'h9000; cpu_rw = 1'b1;
    cfg_we = 1'b1; cfg_addr = 4'd8; cfg_wdata = 8'h03;
    #1;
    n_vec++;
    if (!(sel_rom_int && !sel_ram)) begin
      n_bad++;
      $display("FAIL R12 pre-edge actual=%b%b expected=10", sel_rom_int, sel_ram);
    end
    @(negedge clk);
    cfg_we = 1'b0;
    m_mode = 2'b11; m_xen = 1'b0; m_two = 1'b0; m_dense = 1'b0;
    apply(16'h9000, 1'b1, "R12 post-edge");
    // R12 writes to unused addresses are ignored
    for (int ad = 9; ad < 16; ad++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 4'(ad); cfg_wdata = 8'hFF;
      @(negedge clk);
      cfg_we = 1'b0;
    end
    sweep("R12 ignored cfg address");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule